// File: doc/BRIEF.md
# Page Write Collector and Commit Engine

This block sits behind the target-side protocol engine of a two-wire serial memory. The engine decodes bus traffic into simple one-cycle events: a new transaction begins, the word address has been received, a data byte has been received, the transaction ended normally, or it broke off. The block keeps the received data bytes in a page-sized holding buffer. Nothing reaches the memory array until the transaction ends normally.

When a normal stop arrives, the block starts one timed internal programming cycle. It raises a busy flag for a fixed number of clocks, and the protocol engine uses that flag to refuse selection. In the first clocks of that cycle the block writes each page location that received a byte to the array port, in ascending offset order. A write-protect input, a break-off, or a new start before the stop throws the buffered bytes away and leaves the array untouched.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low, and no transaction is open.
- R2: An address load captures the upper address bits (the page, `addr_i[ADDR_W-1:5]` by default) and the low offset bits. Every array write of the transaction goes to that page, with `mem_addr_o = {page, offset}`.
- R3: Each data byte is stored at the current offset. The offset then increases by one and wraps from the last offset of the page (31) to offset 0. The page bits never change.
- R4: When more than PAGE_BYTES bytes arrive, a later byte that wraps onto an offset replaces the earlier byte there. Only the last value is programmed.
- R5: No array write happens before the stop. A stop with at least one byte buffered and `wp_i` low raises `busy_o` on the next clock, holds it for exactly WRITE_CYCLES clocks, and then drops it.
- R6: In busy clock j (counted from 0, for j < PAGE_BYTES), offset j is written if and only if it received a byte. Each received offset is therefore written exactly once, with its buffered data.
- R7: A single-byte transaction commits exactly one location, the loaded address.
- R8: A stop while `wp_i` is high writes nothing, raises no busy, and discards the buffer.
- R9: An abort or a start before the stop discards the buffer. A later stop without a new address load writes nothing.
- R10: While `busy_o` is high, all transaction inputs (start, address load, data, stop, abort, write-protect) are ignored. The commit in progress completes unchanged, and no transaction is open afterwards.
- R11: A stop with no buffered byte raises no busy and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start event seen on the bus |
| addr_load_i | input | 1 | Word address received; opens a transaction |
| addr_i | input | ADDR_W | Word address captured on `addr_load_i` |
| data_valid_i | input | 1 | One data byte received |
| data_i | input | 8 | Data byte value |
| stop_i | input | 1 | Normal stop event |
| abort_i | input | 1 | Transaction broken off |
| wp_i | input | 1 | Write protect, sampled at the stop |
| busy_o | output | 1 | Internal programming cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The commit path is exercised with several kinds of transaction: a short run in the middle of a page, a run that starts near the end of a page and wraps, a run longer than a page, and a single byte at the top address. Together they separate wrap-within-page from carry into the page bits, and last-value-wins from first-value-wins. Negative patterns cover a protected stop, a break-off, a start before the stop, an empty stop, and traffic during busy; each would show up as a stray array write. A cycle-accurate behavioural model predicts busy and every write strobe, address and data value on each clock.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2
    } pwb_state_e;

endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic [OFS_W-1:0]  wr_ofs_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [OFS_W-1:0]  rd_ofs_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o,
    output logic              any_vld_o
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] dat;
        logic [PAGE_BYTES-1:0]             vld;
    } buf_s;

    buf_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.vld = '0;
        end else if (wr_en_i) begin
            s_d.dat[wr_ofs_i] = wr_data_i;
            s_d.vld[wr_ofs_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data_o = s_q.dat[rd_ofs_i];
    assign rd_vld_o  = s_q.vld[rd_ofs_i];
    assign any_vld_o = |s_q.vld;

    // R3: a stored byte marks its own offset as received
    p_byte_marked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_i) |=> s_q.vld[$past(wr_ofs_i)]);

    // R4: the stored value is the most recent byte for that offset
    p_last_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_i) |=> (s_q.dat[$past(wr_ofs_i)] == $past(wr_data_i)));

endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
    parameter int CYCLES = 40,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic last_o
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!t_q.run) begin
            if (start_i) begin
                t_d.run = 1'b1;
                t_d.cnt = CNT_W'(CYCLES - 1);
            end
        end else if (t_q.cnt == '0) begin
            t_d.run = 1'b0;
        end else begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o = t_q.run;
    assign last_o = t_q.run && (t_q.cnt == '0);

    // R5: busy holds while the count has not expired
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.run && t_q.cnt != '0) |=> t_q.run);

    // R5: busy only drops after the final counted clock
    p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(t_q.run) |-> ($past(t_q.cnt) == '0));

endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq #(
    parameter int PAGE_BYTES = 32,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PAGE_BYTES - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             active_o,
    output logic [OFS_W-1:0] idx_o
);

    typedef struct packed {
        logic             act;
        logic [OFS_W-1:0] idx;
    } seq_s;

    seq_s q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (!q_q.act) begin
            if (start_i) begin
                q_d.act = 1'b1;
                q_d.idx = '0;
            end
        end else if (q_q.idx == LAST_OFS) begin
            q_d.act = 1'b0;
        end else begin
            q_d.idx = q_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign active_o = q_q.act;
    assign idx_o    = q_q.idx;

    // R6: offsets are visited in ascending order, one per clock
    p_seq_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.act && q_q.idx != LAST_OFS) |=> (q_q.act && q_q.idx == $past(q_q.idx) + 1'b1));

endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
    import pwb_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 40,
    localparam int OFS_W       = $clog2(PAGE_BYTES),
    localparam int PAGE_W      = ADDR_W - OFS_W,
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PAGE_BYTES - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_valid_i,
    input  logic [7:0]        data_i,
    input  logic              stop_i,
    input  logic              abort_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o
);

    if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_len
        $error("WRITE_CYCLES must cover one clock per page offset");
    end

    typedef struct packed {
        pwb_state_e        st;
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  ofs;
    } ctl_s;

    ctl_s c_d, c_q;

    logic             buf_clr, buf_wr, buf_rd_vld, buf_any;
    logic [7:0]       buf_rd_data;
    logic             commit_go;
    logic             tmr_busy, tmr_last;
    logic             seq_act;
    logic [OFS_W-1:0] seq_idx;

    always_comb begin
        c_d       = c_q;
        buf_clr   = 1'b0;
        buf_wr    = 1'b0;
        commit_go = 1'b0;
        unique case (c_q.st)
            ST_PROGRAM: begin
                if (tmr_last) begin
                    c_d.st  = ST_IDLE;
                    buf_clr = 1'b1;
                end
            end
            default: begin
                if (abort_i || start_i) begin
                    c_d.st  = ST_IDLE;
                    buf_clr = 1'b1;
                end else if (stop_i) begin
                    if (c_q.st == ST_COLLECT && buf_any && !wp_i) begin
                        c_d.st    = ST_PROGRAM;
                        commit_go = 1'b1;
                    end else begin
                        c_d.st  = ST_IDLE;
                        buf_clr = 1'b1;
                    end
                end else if (addr_load_i) begin
                    c_d.st   = ST_COLLECT;
                    c_d.page = addr_i[ADDR_W-1:OFS_W];
                    c_d.ofs  = addr_i[OFS_W-1:0];
                    buf_clr  = 1'b1;
                end else if (data_valid_i && c_q.st == ST_COLLECT) begin
                    buf_wr  = 1'b1;
                    c_d.ofs = c_q.ofs + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, page: '0, ofs: '0};
        else        c_q <= c_d;
    end

    pwb_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(8)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .wr_en_i   (buf_wr),
        .wr_ofs_i  (c_q.ofs),
        .wr_data_i (data_i),
        .rd_ofs_i  (seq_idx),
        .rd_data_o (buf_rd_data),
        .rd_vld_o  (buf_rd_vld),
        .any_vld_o (buf_any)
    );

    pwb_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit_go),
        .busy_o  (tmr_busy),
        .last_o  (tmr_last)
    );

    pwb_commit_seq #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (commit_go),
        .active_o (seq_act),
        .idx_o    (seq_idx)
    );

    assign busy_o      = tmr_busy;
    assign mem_we_o    = seq_act && buf_rd_vld;
    assign mem_addr_o  = {c_q.page, seq_idx};
    assign mem_wdata_o = buf_rd_data;

    // R5: the array is only written inside the programming cycle
    p_write_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    // R5: control state and timer agree on the programming cycle
    p_state_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_PROGRAM) == busy_o);

    // R3: offset wraps from the last page byte back to the first
    p_ofs_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && c_q.ofs == LAST_OFS) |=> (c_q.ofs == '0));

    // R8: a protected stop never starts a programming cycle
    p_wp_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && wp_i) |=> !busy_o);

    // R10: the page under commit cannot change while busy
    p_page_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(c_q.page));

endmodule

// File: tb/tb_pwb_page_writer.sv
module tb_pwb_page_writer;

    localparam int AW = 13;
    localparam int PB = 32;
    localparam int WC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 0, addr_load_i = 0, data_valid_i = 0;
    logic          stop_i = 0, abort_i = 0, wp_i = 0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    data_i = '0;
    logic          busy_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_wdata_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwb_page_writer #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_load_i(addr_load_i),
        .addr_i(addr_i), .data_valid_i(data_valid_i), .data_i(data_i),
        .stop_i(stop_i), .abort_i(abort_i), .wp_i(wp_i), .busy_o(busy_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int       m_left = 0;
    bit       m_open = 0;
    int       m_page = 0, m_ofs = 0, m_idx = 0;
    bit [7:0] m_buf [PB];
    bit       m_vld [PB];
    byte      smem [int];
    int       wr_count [int];
    bit       prev_busy = 0;
    int       run_len = 0;

    function automatic bit m_any();
        foreach (m_vld[i]) if (m_vld[i]) return 1;
        return 0;
    endfunction

    function automatic void m_clear();
        foreach (m_vld[i]) m_vld[i] = 0;
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            if (m_left > 0) begin
                m_left--;
                m_idx++;
                if (m_left == 0) begin m_clear(); m_open = 0; end
            end else if (abort_i || start_i) begin
                m_open = 0; m_clear();
            end else if (stop_i) begin
                if (m_open && m_any() && !wp_i) begin
                    m_left = WC; m_idx = 0;
                end else m_clear();
                m_open = 0;
            end else if (addr_load_i) begin
                m_open = 1; m_page = int'(addr_i) / PB; m_ofs = int'(addr_i) % PB; m_clear();
            end else if (data_valid_i && m_open) begin
                m_buf[m_ofs] = data_i; m_vld[m_ofs] = 1; m_ofs = (m_ofs + 1) % PB;
            end
        end
        #2;
        if (rst_n) begin
            bit exp_we;
            exp_we = (m_left > 0) && (m_idx < PB) && m_vld[m_idx];
            chk(busy_o == (m_left > 0), "R5", "busy", int'(busy_o), int'(m_left > 0));
            chk(mem_we_o == exp_we, "R6", "write strobe", int'(mem_we_o), int'(exp_we));
            if (exp_we && mem_we_o) begin
                chk(int'(mem_addr_o) == m_page * PB + m_idx, "R2", "write address",
                    int'(mem_addr_o), m_page * PB + m_idx);
                chk(mem_wdata_o == m_buf[m_idx], "R6", "write data",
                    int'(mem_wdata_o), int'(m_buf[m_idx]));
            end
            if (mem_we_o) begin
                smem[int'(mem_addr_o)] = mem_wdata_o;
                if (wr_count.exists(int'(mem_addr_o))) wr_count[int'(mem_addr_o)]++;
                else wr_count[int'(mem_addr_o)] = 1;
            end
            if (busy_o) run_len++;
            if (prev_busy && !busy_o) begin
                chk(run_len == WC, "R5", "busy length", run_len, WC);
                run_len = 0;
            end
            prev_busy = busy_o;
        end
    end

    task automatic pulse_addr(input int a);
        @(negedge clk); addr_load_i = 1; addr_i = AW'(a);
        @(negedge clk); addr_load_i = 0;
    endtask
    task automatic pulse_data(input int d);
        @(negedge clk); data_valid_i = 1; data_i = 8'(d);
        @(negedge clk); data_valid_i = 0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); stop_i = 1;
        @(negedge clk); stop_i = 0;
    endtask
    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int mem_at(input int a);
        return smem.exists(a) ? int'(smem[a]) & 255 : -1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_o == 0, "R1", "busy after reset", int'(busy_o), 0);
        chk(mem_we_o == 0, "R1", "write strobe after reset", int'(mem_we_o), 0);
        rst_n = 1;
        @(negedge clk);
        chk(busy_o == 0, "R1", "busy after release", int'(busy_o), 0);

        // R2 R3 R5 R6: short run in the middle of page 9
        pulse_addr('h123);
        pulse_data('hAA); pulse_data('hBB); pulse_data('hCC);
        repeat (3) @(negedge clk);
        chk(mem_at('h123) == -1, "R5", "no write before stop", mem_at('h123), -1);
        pulse_stop();
        chk(busy_o == 1, "R5", "busy after stop", int'(busy_o), 1);
        wait_idle();
        chk(mem_at('h123) == 'hAA, "R2", "byte 0", mem_at('h123), 'hAA);
        chk(mem_at('h124) == 'hBB, "R3", "byte 1", mem_at('h124), 'hBB);
        chk(mem_at('h125) == 'hCC, "R6", "byte 2", mem_at('h125), 'hCC);
        chk(mem_at('h126) == -1, "R6", "unreceived offset", mem_at('h126), -1);

        // R3: wrap inside page 2
        pulse_addr('h5E);
        pulse_data('h11); pulse_data('h22); pulse_data('h33);
        pulse_stop(); wait_idle();
        chk(mem_at('h5F) == 'h22, "R3", "last offset", mem_at('h5F), 'h22);
        chk(mem_at('h40) == 'h33, "R3", "wrapped to page start", mem_at('h40), 'h33);
        chk(mem_at('h60) == -1, "R3", "no carry into page bits", mem_at('h60), -1);

        // R4: 34 bytes into page 16
        pulse_addr('h200);
        for (int i = 0; i < 34; i++) pulse_data(i + 1);
        pulse_stop(); wait_idle();
        chk(mem_at('h200) == 33, "R4", "offset 0 overwritten", mem_at('h200), 33);
        chk(mem_at('h201) == 34, "R4", "offset 1 overwritten", mem_at('h201), 34);
        chk(mem_at('h202) == 3, "R4", "offset 2 kept", mem_at('h202), 3);
        chk(wr_count['h200] == 1, "R6", "single write per offset", wr_count['h200], 1);

        // R7: single byte at the top address
        pulse_addr('h1FFF); pulse_data('h5A); pulse_stop(); wait_idle();
        chk(mem_at('h1FFF) == 'h5A, "R7", "single byte", mem_at('h1FFF), 'h5A);
        chk(mem_at('h1FE0) == -1, "R7", "no other location", mem_at('h1FE0), -1);

        // R8: write protect
        pulse_addr('h300); pulse_data('h77);
        @(negedge clk); wp_i = 1; stop_i = 1;
        @(negedge clk); stop_i = 0;
        chk(busy_o == 0, "R8", "no busy when protected", int'(busy_o), 0);
        wp_i = 0;
        pulse_stop(); wait_idle();
        chk(mem_at('h300) == -1, "R8", "protected location", mem_at('h300), -1);

        // R9: abort, and start before stop
        pulse_addr('h400); pulse_data('h66);
        @(negedge clk); abort_i = 1; @(negedge clk); abort_i = 0;
        pulse_stop(); wait_idle();
        chk(mem_at('h400) == -1, "R9", "after abort", mem_at('h400), -1);
        pulse_addr('h420); pulse_data('h67);
        @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
        pulse_stop();
        chk(busy_o == 0, "R9", "no busy after restart", int'(busy_o), 0);
        wait_idle();
        chk(mem_at('h420) == -1, "R9", "after start", mem_at('h420), -1);

        // R10: traffic during busy
        pulse_addr('h500); pulse_data('h12); pulse_stop();
        @(negedge clk); abort_i = 1; start_i = 1; @(negedge clk); abort_i = 0; start_i = 0;
        pulse_addr('h600); pulse_data('h99);
        @(negedge clk); wp_i = 1; stop_i = 1; @(negedge clk); wp_i = 0; stop_i = 0;
        wait_idle();
        pulse_stop(); wait_idle();
        chk(mem_at('h500) == 'h12, "R10", "commit survived abort", mem_at('h500), 'h12);
        chk(mem_at('h600) == -1, "R10", "address load ignored", mem_at('h600), -1);

        // R11: empty stop
        pulse_addr('h700); pulse_stop();
        chk(busy_o == 0, "R11", "no busy on empty stop", int'(busy_o), 0);
        wait_idle();
        chk(mem_at('h700) == -1, "R11", "no write on empty stop", mem_at('h700), -1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule